// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines and forwards the most urgent one to an 8-bit CPU on a single interrupt output. It keeps three registers: pending requests, mask and in-service. Line 0 is the most urgent and line 7 the least. A request is forwarded only if it is unmasked and more urgent than every interrupt already in service. Lower-priority requests wait, and higher-priority ones nest.

The CPU answers the interrupt with three acknowledge pulses. The controller returns a subroutine-call opcode on the first pulse, then the low byte of a vector address, then the high byte. The vector is a programmable base plus the line index times a programmable spacing of 4 or 8 bytes. A small register port (chip select, read and write strobes, one address bit) loads the configuration, the mask and the end-of-interrupt and read-select commands, and reads back the registers. All port traffic is synchronous to `clk`. Strobes are one-cycle pulses sampled on the rising edge, and read or acknowledge data appears on `dout` after that edge and holds until the next access.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the state is as follows. `int_out` is 0 and `dout` is 0x00. The mask is 0x00, sensing is edge mode, spacing is 4, the base is 0x0000 and reads with `a0`=0 return the request register.
- R2: When mask bit i (bit i = line i) is 1, line i never raises `int_out`. Its request is still recorded in the request register. A write with `a0`=1 loads the mask, and a read with `a0`=1 returns it.
- R3: Priority is fixed, with line 0 highest. `int_out` rises only when the highest unmasked pending line has a lower index than every set in-service bit.
- R4: Three acknowledge pulses return 0xCD, then the vector low byte, then the vector high byte. On the first pulse `int_out` falls, the winning in-service bit is set and its request bit is cleared. `int_out` stays low until the third pulse.
- R5: Vector = base with bits 4:0 cleared (spacing 4) or bits 5:0 cleared (spacing 8), plus index × spacing.
- R6: A command write (`a0`=0) with bits 7:6 = 11 is a configuration byte. Bit 0 selects level sensing (1) or edge sensing (0), bit 1 selects spacing 8 (1) or 4 (0), and bits 4:2 give base bits 7:5. The next `a0`=0 write is taken as base bits 15:8.
- R7: Command 0x20 clears the highest-priority in-service bit.
- R8: Command 0x0A makes `a0`=0 reads return the request register, and 0x0B makes them return the in-service register.
- R9: In edge mode a rising input edge latches a request. A line held high after being acknowledged makes no new request.
- R10: In level mode the request bit follows the input. A line dropped before the acknowledge withdraws the interrupt, and a line still high after end-of-interrupt requests again.
- R11: If no request qualifies at the first acknowledge pulse, the sequence returns the vector of line 7 and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, bit i = line i |
| cs | input | 1 | Register port select |
| wr | input | 1 | Write strobe (with cs) |
| rd | input | 1 | Read strobe (with cs) |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read / acknowledge data |
| inta | input | 1 | Acknowledge pulse from the CPU |
| int_out | output | 1 | Interrupt request to the CPU |

## Verification
The bench nests a more urgent request under one in service and checks that a less urgent request is held back. A resolver that compared against only the newest in-service bit, or ignored it, would raise the interrupt too early. End-of-interrupt is issued with two bits in service, and a version that cleared the wrong bit would let the blocked line through at the wrong moment. Vectors are checked at both spacings with a base whose low bits must be dropped; dropping the wrong bits corrupts the low byte. Level and edge lines are held high across acknowledge and end-of-interrupt, a request is withdrawn before the acknowledge, and a masked line is checked to be recorded but never forwarded.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NIRQ   = 8;
  localparam int IDX_W  = $clog2(NIRQ);
  localparam int DW     = 8;
  localparam int VW     = 16;
  localparam logic [DW-1:0] CALL_OP    = 8'hCD;
  localparam logic [DW-1:0] CMD_EOI    = 8'h20;
  localparam logic [DW-1:0] CMD_RD_REQ = 8'h0A;
  localparam logic [DW-1:0] CMD_RD_SRV = 8'h0B;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } ack_ph_t;
endpackage

// File: rtl/irq_req_sense.sv
module irq_req_sense #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         level_mode,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);
  logic [N-1:0] prev_q;
  logic [N-1:0] req_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[g] <= 1'b0;
        req_q[g]  <= 1'b0;
      end else begin
        prev_q[g] <= lines[g];
        if (level_mode)
          req_q[g] <= lines[g] & ~clr[g];
        else
          req_q[g] <= (req_q[g] & ~clr[g]) | (lines[g] & ~prev_q[g]);
      end
    end
  end

  assign req = req_q;
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     srv,
  output logic             raise,
  output logic [IDX_W-1:0] win_idx,
  output logic [N-1:0]     win_onehot,
  output logic [N-1:0]     top_srv_onehot
);
  logic [N-1:0]     pend;
  logic             p_valid, s_valid;
  logic [IDX_W-1:0] p_idx, s_idx;

  always_comb begin
    pend    = req & ~mask;
    p_valid = 1'b0;
    s_valid = 1'b0;
    p_idx   = '0;
    s_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        p_valid = 1'b1;
        p_idx   = IDX_W'(i);
      end
      if (srv[i]) begin
        s_valid = 1'b1;
        s_idx   = IDX_W'(i);
      end
    end
    raise          = p_valid && (!s_valid || (p_idx < s_idx));
    win_idx        = p_idx;
    win_onehot     = p_valid ? (N'(1) << p_idx) : '0;
    top_srv_onehot = s_valid ? (N'(1) << s_idx) : '0;
  end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int VW    = 16,
  parameter int IDX_W = 3
) (
  input  logic [VW-1:0]    base,
  input  logic             wide,
  input  logic [IDX_W-1:0] idx,
  output logic [VW-1:0]    vec
);
  localparam int SH4 = 2;
  localparam int SH8 = 3;
  localparam logic [VW-1:0] ALN4 = VW'((1 << (IDX_W + SH4)) - 1);
  localparam logic [VW-1:0] ALN8 = VW'((1 << (IDX_W + SH8)) - 1);

  always_comb begin
    if (wide)
      vec = (base & ~ALN8) | (VW'(idx) << SH8);
    else
      vec = (base & ~ALN4) | (VW'(idx) << SH4);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [NIRQ-1:0] irq_in,
  input  logic          cs,
  input  logic          wr,
  input  logic          rd,
  input  logic          a0,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic          inta,
  output logic          int_out
);
  logic [NIRQ-1:0]  irr_q, mask_q, isr_q, isr_nxt;
  logic [NIRQ-1:0]  win_oh, eoi_oh, req_clr;
  logic [IDX_W-1:0] win_idx, win_q;
  logic             raise, level_q, wide_q, rsel_q, hi_wait_q, int_q;
  logic [VW-1:0]    base_q, vec;
  logic [DW-1:0]    dout_q;
  ack_ph_t          phase_q;
  logic             wr_cmd, wr_mask, rd_acc, ack_first, take, is_cfg, do_eoi;

  assign wr_cmd    = cs & wr & ~a0;
  assign wr_mask   = cs & wr & a0;
  assign rd_acc    = cs & rd;
  assign ack_first = inta && (phase_q == PH_IDLE);
  assign take      = ack_first && raise;
  assign req_clr   = take ? win_oh : '0;
  assign is_cfg    = wr_cmd && !hi_wait_q && (din[7:6] == 2'b11);
  assign do_eoi    = wr_cmd && !hi_wait_q && (din == CMD_EOI);

  irq_req_sense #(.N(NIRQ)) u_sense (
    .clk(clk), .rst(rst), .level_mode(level_q),
    .lines(irq_in), .clr(req_clr), .req(irr_q)
  );

  irq_resolver #(.N(NIRQ), .IDX_W(IDX_W)) u_res (
    .req(irr_q), .mask(mask_q), .srv(isr_q),
    .raise(raise), .win_idx(win_idx),
    .win_onehot(win_oh), .top_srv_onehot(eoi_oh)
  );

  irq_vector_gen #(.VW(VW), .IDX_W(IDX_W)) u_vec (
    .base(base_q), .wide(wide_q), .idx(win_q), .vec(vec)
  );

  always_comb begin
    isr_nxt = isr_q;
    if (do_eoi) isr_nxt = isr_nxt & ~eoi_oh;
    if (take)   isr_nxt = isr_nxt | win_oh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      isr_q     <= '0;
      level_q   <= 1'b0;
      wide_q    <= 1'b0;
      rsel_q    <= 1'b0;
      hi_wait_q <= 1'b0;
      base_q    <= '0;
      win_q     <= '1;
      phase_q   <= PH_IDLE;
      int_q     <= 1'b0;
      dout_q    <= '0;
    end else begin
      isr_q <= isr_nxt;
      if (wr_mask) mask_q <= din;
      if (wr_cmd) begin
        if (hi_wait_q) begin
          base_q[VW-1:DW] <= din;
          hi_wait_q       <= 1'b0;
        end else if (is_cfg) begin
          level_q        <= din[0];
          wide_q         <= din[1];
          base_q[DW-1:0] <= {din[4:2], 5'b0};
          hi_wait_q      <= 1'b1;
        end else if (din == CMD_RD_REQ) begin
          rsel_q <= 1'b0;
        end else if (din == CMD_RD_SRV) begin
          rsel_q <= 1'b1;
        end
      end
      if (inta) begin
        unique case (phase_q)
          PH_IDLE: begin
            dout_q  <= CALL_OP;
            win_q   <= raise ? win_idx : '1;
            phase_q <= PH_LOW;
          end
          PH_LOW: begin
            dout_q  <= vec[DW-1:0];
            phase_q <= PH_HIGH;
          end
          default: begin
            dout_q  <= vec[VW-1:DW];
            phase_q <= PH_IDLE;
          end
        endcase
      end else if (rd_acc) begin
        dout_q <= a0 ? mask_q : (rsel_q ? isr_q : irr_q);
      end
      int_q <= raise && (phase_q == PH_IDLE) && !inta;
    end
  end

  assign dout    = dout_q;
  assign int_out = int_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       int_out,
  input logic       inta,
  input logic [7:0] dout,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] mask,
  input logic [1:0] phase
);
  p_int_unmasked_r2: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(|(irr & ~mask)));

  p_isr_one_step_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(isr) <= $countones($past(isr)) + 1));

  p_call_first_r4: assert property (@(posedge clk) disable iff (rst)
    (inta && phase == 2'd0) |=> (dout == 8'hCD));

  p_seq_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (inta && phase == 2'd2) |=> (phase == 2'd0));

  p_int_idle_r4: assert property (@(posedge clk) disable iff (rst)
    int_out |-> (phase == 2'd0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .int_out(int_out), .inta(inta), .dout(dout),
  .irr(irr_q), .isr(isr_q), .mask(mask_q), .phase(phase_q)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       cs = 0, wr = 0, rd = 0, a0 = 0, inta = 0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       int_out;
  int         total = 0;
  int         bad = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cs(cs), .wr(wr), .rd(rd),
    .a0(a0), .din(din), .dout(dout), .inta(inta), .int_out(int_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cpu_wr(input logic adr, input logic [7:0] d);
    cs = 1; wr = 1; a0 = adr; din = d;
    step(1);
    cs = 0; wr = 0;
  endtask

  task automatic cpu_rd(input logic adr, output logic [7:0] d);
    cs = 1; rd = 1; a0 = adr;
    step(1);
    cs = 0; rd = 0;
    d = dout;
  endtask

  task automatic ack(output logic [7:0] b);
    inta = 1;
    step(1);
    inta = 0;
    b = dout;
    step(1);
  endtask

  task automatic pulse(input int ln);
    irq_in[ln] = 1'b1;
    step(2);
    irq_in[ln] = 1'b0;
    step(3);
  endtask

  function automatic logic [15:0] exp_vec(input logic [15:0] base, input bit wide, input int idx);
    if (wide) return (base & ~16'h003F) + 16'(idx * 8);
    return (base & ~16'h001F) + 16'(idx * 4);
  endfunction

  task automatic ack_seq(input string tag, input logic [15:0] v);
    logic [7:0] b;
    ack(b);
    check({tag, " R4 opcode"}, b, 16'h00CD);
    check({tag, " R4 int low after first ack"}, int_out, 0);
    ack(b);
    check({tag, " R5 vector low"}, b, v & 16'h00FF);
    ack(b);
    check({tag, " R5 vector high"}, b, v >> 8);
  endtask

  task automatic read_srv(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    cpu_wr(0, 8'h0B);
    cpu_rd(0, v);
    check({tag, " R8 in-service read"}, v, exp);
  endtask

  task automatic read_req(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    cpu_wr(0, 8'h0A);
    cpu_rd(0, v);
    check({tag, " R8 request read"}, v, exp);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 int after reset", int_out, 0);
    check("R1 dout after reset", dout, 0);
    cpu_rd(1, v);
    check("R1 mask after reset", v, 0);
    cpu_rd(0, v);
    check("R1 read select request", v, 0);
  endtask

  task automatic t_basic();
    cpu_wr(0, 8'hF4);
    cpu_wr(0, 8'h12);
    pulse(3);
    check("R6 R9 int on edge request", int_out, 1);
    ack_seq("basic", exp_vec(16'h12A0, 0, 3));
    read_srv("basic", 8'h08);
    read_req("basic R4 request cleared", 8'h00);
  endtask

  task automatic t_nest();
    pulse(5);
    check("R3 lower priority held", int_out, 0);
    pulse(1);
    check("R3 higher priority nests", int_out, 1);
    ack_seq("nest", exp_vec(16'h12A0, 0, 1));
    read_srv("nest", 8'h0A);
  endtask

  task automatic t_eoi();
    cpu_wr(0, 8'h20);
    step(3);
    read_srv("R7 first eoi", 8'h08);
    check("R7 line5 still blocked", int_out, 0);
    cpu_wr(0, 8'h20);
    step(3);
    check("R7 line5 released", int_out, 1);
    ack_seq("eoi", exp_vec(16'h12A0, 0, 5));
    cpu_wr(0, 8'h20);
    step(2);
    read_srv("R7 empty", 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    cpu_wr(1, 8'h04);
    cpu_rd(1, v);
    check("R2 mask readback", v, 8'h04);
    pulse(2);
    check("R2 masked line silent", int_out, 0);
    read_req("R2 masked recorded", 8'h04);
    cpu_wr(1, 8'h00);
    step(3);
    check("R2 unmask raises", int_out, 1);
    ack_seq("mask", exp_vec(16'h12A0, 0, 2));
    cpu_wr(0, 8'h20);
    step(2);
  endtask

  task automatic t_wide();
    cpu_wr(0, 8'hCE);
    cpu_wr(0, 8'h34);
    pulse(6);
    check("R6 wide config int", int_out, 1);
    ack_seq("R5 spacing8", exp_vec(16'h3460, 1, 6));
    cpu_wr(0, 8'h20);
    step(2);
  endtask

  task automatic t_level();
    logic [7:0] b;
    cpu_wr(0, 8'hC1);
    cpu_wr(0, 8'h00);
    irq_in[4] = 1'b1;
    step(3);
    check("R10 level raises", int_out, 1);
    read_req("R10 level follows", 8'h10);
    irq_in[4] = 1'b0;
    step(3);
    check("R10 withdrawn", int_out, 0);
    ack(b);
    check("R11 spurious opcode", b, 16'h00CD);
    ack(b);
    check("R11 spurious vector low", b, exp_vec(16'h0000, 0, 7) & 16'h00FF);
    ack(b);
    check("R11 spurious vector high", b, 0);
    read_srv("R11 no service", 8'h00);
    irq_in[4] = 1'b1;
    step(3);
    ack_seq("level", exp_vec(16'h0000, 0, 4));
    step(3);
    check("R10 no self nest", int_out, 0);
    cpu_wr(0, 8'h20);
    step(3);
    check("R10 re-request after eoi", int_out, 1);
    irq_in[4] = 1'b0;
    step(3);
    check("R10 dropped again", int_out, 0);
  endtask

  task automatic t_edge_hold();
    cpu_wr(0, 8'hC0);
    cpu_wr(0, 8'h00);
    irq_in[0] = 1'b1;
    step(3);
    check("R9 edge request", int_out, 1);
    ack_seq("edge", exp_vec(16'h0000, 0, 0));
    cpu_wr(0, 8'h20);
    step(4);
    check("R9 held line no re-request", int_out, 0);
    irq_in[0] = 1'b0;
    step(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    step(3);
    rst = 0;
    step(1);
    t_reset();
    t_basic();
    t_nest();
    t_eoi();
    t_mask();
    t_wide();
    t_level();
    t_edge_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule